// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader

This block converts a stream of payload bytes into a direct-sequence chip stream at one chip every eight system clocks (2 Mchip/s from a 16 MHz clock). Each byte is cut into two 4-bit symbols, low half first. Each symbol selects one of sixteen fixed 32-chip pseudo-random codes, and the code is sent chip 0 first. The chips are also split onto two offset rails for a downstream half-sine pulse shaper. Even-numbered chips go to the in-phase rail. Odd-numbered chips go to the quadrature rail, half a chip period later.

The sixteen codes are not stored as a table. They are derived from one base code. Symbols 1 to 7 are the base code delayed by four chips per symbol step. Symbols 8 to 15 repeat symbols 0 to 7 with every odd-numbered chip inverted.

A `start` pulse opens a stream. Bytes are taken over a valid/ready handshake: one byte when the stream opens, then one byte in the final clock of each byte's 64th chip. This gives back-to-back bytes with no gap. If no byte is offered at a take point, the block flags an underrun and goes quiet until the next `start`.

Top module: `dsss_spreader`

## Requirements
- R1: Within a byte, the 32 chips of the low nibble (bits 3:0) are sent before the 32 chips of the high nibble (bits 7:4).
- R2: Symbol 0 sends chips C0..C31 = 1101 1001 1100 0011 0101 0010 0010 1110 (C0 leftmost).
- R3: For symbols s = 1..7, chip k equals chip (k - 4s) mod 32 of the symbol 0 code.
- R4: For symbols s = 8..15, chip k equals chip k of symbol s-8, inverted when k is odd.
- R5: While `active` is high, `chipStb` pulses for one clock exactly every 8 clocks, and `chipVal` carries the current chip during that clock. The first strobe comes in the clock after the first byte is accepted.
- R6: One clock after the strobe of an even-numbered chip (index 0..63 within the byte), `iChip` holds that chip and keeps it until the next even chip.
- R7: Five clocks after the strobe of an even-numbered chip, that is 4 clocks after `iChip` updates, `qChip` holds the following odd-numbered chip.
- R8: `inReady` is high only in the clock after `start` and in the last clock of the 64th chip of a byte. A byte accepted there starts its chips at once, so consecutive bytes leave no gap in the strobe spacing.
- R9: If `inValid` is low while `inReady` is high, `underrun` is set. In the same step `active`, `chipStb`, `iChip` and `qChip` go to 0 and stay there.
- R10: A `start` pulse while `active` is high has no effect on the chip stream.
- R11: A `start` pulse while idle clears `underrun`. If no byte is offered in the clock after `start`, `underrun` is set again without any chip being sent.
- R12: After reset, `inReady`, `chipStb`, `chipVal`, `iChip`, `qChip`, `underrun` and `active` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (16 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a stream when idle |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte offered |
| inReady | output | 1 | Byte taken this clock when `inValid` is high |
| chipStb | output | 1 | One-clock pulse at the start of each chip |
| chipVal | output | 1 | Current chip value |
| iChip | output | 1 | In-phase rail (even chips) |
| qChip | output | 1 | Quadrature rail (odd chips, half-chip delay) |
| underrun | output | 1 | No byte was offered when one was due |
| active | output | 1 | Chip stream running |

## Verification
The bench streams all 256 byte values back to back and checks every emitted chip against codes it rebuilds from the rotate and invert rule. A wrong rotation direction, a misplaced inversion or a swapped nibble order therefore shows up as a chip mismatch in the affected symbols. It times the in-phase and quadrature updates relative to each strobe, which catches a rail that takes the wrong chip or lands a clock early or late. It checks that the strobe gap stays at eight clocks across byte boundaries, which catches a one-clock bubble at the take point. It also checks that a `start` pulse in mid-stream leaves the stream intact. Finally it opens a stream with no data and lets a stream run dry, to confirm the underrun flag and quiet outputs in both cases.

// File: rtl/spreader_pkg.sv
package spreader_pkg;
  localparam int SYM_BITS      = 4;
  localparam int NUM_SYMS      = 1 << SYM_BITS;
  localparam int CHIPS_PER_SYM = 32;
  localparam int CHIP_IDX_W    = $clog2(CHIPS_PER_SYM);
  localparam int BYTE_CHIPS    = 2 * CHIPS_PER_SYM;
  localparam int BYTE_IDX_W    = $clog2(BYTE_CHIPS);
  localparam int ROT_STEP      = 4;

  // Bit k of this word is chip k of symbol 0.
  localparam logic [CHIPS_PER_SYM-1:0] BASE_CODE = 32'h744AC39B;

  typedef struct packed {
    logic                  load;
    logic                  latchI;
    logic                  latchQ;
    logic                  clear;
    logic [BYTE_IDX_W-1:0] chipIdx;
  } ctrlStrobes_t;

  // Symbols 1..7 delay the base code by ROT_STEP chips per step; the upper
  // half of the symbol range inverts the odd chips.
  function automatic logic [CHIPS_PER_SYM-1:0] symbolCode(input int unsigned sym);
    logic [CHIPS_PER_SYM-1:0] code;
    int unsigned shift;
    shift = (sym % (NUM_SYMS / 2)) * ROT_STEP;
    for (int k = 0; k < CHIPS_PER_SYM; k++) begin
      code[k] = BASE_CODE[(k + CHIPS_PER_SYM - shift) % CHIPS_PER_SYM];
      if (sym >= NUM_SYMS / 2 && (k % 2) == 1) code[k] = ~code[k];
    end
    return code;
  endfunction
endpackage

// File: rtl/spreader_ctrl.sv
module spreader_ctrl
  import spreader_pkg::*;
#(
  parameter int CLKS_PER_CHIP = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         inValid,
  output logic         inReady,
  output logic         chipStb,
  output logic         underrun,
  output logic         active,
  output ctrlStrobes_t strobes
);
  localparam int DIV_W = (CLKS_PER_CHIP > 1) ? $clog2(CLKS_PER_CHIP) : 1;
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(CLKS_PER_CHIP / 2);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_CHIP - 1);
  localparam logic [BYTE_IDX_W-1:0] IDX_LAST = BYTE_IDX_W'(BYTE_CHIPS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} state_t;

  state_t                state;
  logic [DIV_W-1:0]      divCnt;
  logic [BYTE_IDX_W-1:0] chipIdx;
  logic                  lastTick;
  logic                  takeByte;
  logic                  runDry;

  assign active   = (state == ST_RUN);
  assign lastTick = active && divCnt == DIV_LAST && chipIdx == IDX_LAST;
  assign inReady  = (state == ST_LOAD) || lastTick;
  assign takeByte = inReady && inValid;
  assign runDry   = inReady && !inValid;
  assign chipStb  = active && divCnt == '0;

  always_comb begin
    strobes.load    = takeByte;
    strobes.latchI  = chipStb && !chipIdx[0];
    strobes.latchQ  = active && divCnt == DIV_HALF && !chipIdx[0];
    strobes.clear   = runDry;
    strobes.chipIdx = chipIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      chipIdx  <= '0;
      underrun <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOAD;
            underrun <= 1'b0;
          end
        end
        ST_LOAD: begin
          divCnt  <= '0;
          chipIdx <= '0;
          if (inValid) state <= ST_RUN;
          else begin
            state    <= ST_IDLE;
            underrun <= 1'b1;
          end
        end
        default: begin
          if (lastTick) begin
            divCnt  <= '0;
            chipIdx <= '0;
            if (!inValid) begin
              state    <= ST_IDLE;
              underrun <= 1'b1;
            end
          end else if (divCnt == DIV_LAST) begin
            divCnt  <= '0;
            chipIdx <= chipIdx + 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    chipStb |=> !chipStb);
  a_r8_first_chip_next: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> chipStb);
  a_r9_underrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> (underrun && !active));
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (active && !inReady) |=> active);
endmodule

// File: rtl/spreader_datapath.sv
module spreader_datapath
  import spreader_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic         runActive,
  input  logic [7:0]   inData,
  output logic         chipVal,
  output logic         iChip,
  output logic         qChip
);
  logic [CHIPS_PER_SYM-1:0] codeTable [NUM_SYMS];
  logic [7:0]               byteReg;
  logic [SYM_BITS-1:0]      sym;
  logic [CHIPS_PER_SYM-1:0] curCode;
  logic [CHIP_IDX_W-1:0]    chipPos;
  logic                     chipNow;
  logic                     chipNext;

  for (genvar s = 0; s < NUM_SYMS; s++) begin : g_code
    assign codeTable[s] = symbolCode(s);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) byteReg <= '0;
    else if (strobes.load) byteReg <= inData;
  end

  assign sym      = strobes.chipIdx[BYTE_IDX_W-1] ? byteReg[7:4] : byteReg[3:0];
  assign curCode  = codeTable[sym];
  assign chipPos  = strobes.chipIdx[CHIP_IDX_W-1:0];
  assign chipNow  = curCode[chipPos];
  assign chipNext = curCode[chipPos | CHIP_IDX_W'(1)];
  assign chipVal  = runActive & chipNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iChip <= 1'b0;
      qChip <= 1'b0;
    end else if (strobes.clear) begin
      iChip <= 1'b0;
      qChip <= 1'b0;
    end else begin
      if (strobes.latchI) iChip <= chipNow;
      if (strobes.latchQ) qChip <= chipNext;
    end
  end

  a_r6_i_takes_chip: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchI |=> iChip == $past(chipVal));
  a_r7_q_moves_on_latch: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(qChip) |-> $past(strobes.latchQ || strobes.clear));
  a_r9_rails_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (!iChip && !qChip));
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import spreader_pkg::*;
#(
  parameter int CLKS_PER_CHIP = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] inData,
  input  logic       inValid,
  output logic       inReady,
  output logic       chipStb,
  output logic       chipVal,
  output logic       iChip,
  output logic       qChip,
  output logic       underrun,
  output logic       active
);
  ctrlStrobes_t strobes;

  spreader_ctrl #(.CLKS_PER_CHIP(CLKS_PER_CHIP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .inReady  (inReady),
    .chipStb  (chipStb),
    .underrun (underrun),
    .active   (active),
    .strobes  (strobes)
  );

  spreader_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .runActive (active),
    .inData    (inData),
    .chipVal   (chipVal),
    .iChip     (iChip),
    .qChip     (qChip)
  );
endmodule

// File: tb/tb_dsss_spreader.sv
`timescale 1ns/1ps
module tb_dsss_spreader;
  localparam logic [31:0] SYM0_PATTERN = 32'b11011001110000110101001000101110; // C0 is MSB

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inValid = 1'b0;
  logic inReady, chipStb, chipVal, iChip, qChip, underrun, active;

  int checks = 0;
  int fails = 0;
  logic [7:0] accepted [0:511];
  int accCount = 0;
  int nStb = 0;
  int cycle = 0;
  int lastStb = -1;
  int iDue = 0, qDue = 0;
  logic iExp, qExp;
  bit monitorOn = 0;

  always #2 clk = ~clk;

  dsss_spreader dut (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData), .inValid(inValid),
    .inReady(inReady), .chipStb(chipStb), .chipVal(chipVal), .iChip(iChip),
    .qChip(qChip), .underrun(underrun), .active(active)
  );

  function automatic logic expChip(input logic [7:0] b, input int n);
    int nib, k, s, j;
    logic c;
    nib = ((n % 64) < 32) ? int'(b[3:0]) : int'(b[7:4]);
    k = n % 32;
    s = nib % 8;
    j = (k - 4 * s + 32) % 32;
    c = SYM0_PATTERN[31 - j];
    if (nib >= 8 && (k % 2) == 1) c = ~c;
    return c;
  endfunction

  function automatic string symTag(input logic [7:0] b, input int n);
    int nib;
    nib = ((n % 64) < 32) ? int'(b[3:0]) : int'(b[7:4]);
    if (nib == 0) return "R1,R2";
    if (nib < 8) return "R1,R3";
    return "R1,R4";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Chip monitor: every strobe, rail timing and strobe spacing.
  always @(negedge clk) begin
    cycle++;
    if (monitorOn) begin
      if (iDue > 0) begin
        iDue--;
        if (iDue == 0) check(iChip == iExp, "R6 iChip", iChip, iExp);
      end
      if (qDue > 0) begin
        qDue--;
        if (qDue == 0) check(qChip == qExp, "R7 qChip", qChip, qExp);
      end
      if (chipStb) begin
        logic [7:0] b;
        b = accepted[nStb / 64];
        check(chipVal == expChip(b, nStb), symTag(b, nStb), chipVal, expChip(b, nStb));
        check(!inReady, "R8 inReady during strobe", inReady, 0);
        if (lastStb >= 0) check(cycle - lastStb == 8, "R5 strobe spacing", cycle - lastStb, 8);
        lastStb = cycle;
        if ((nStb % 2) == 0) begin
          iDue = 1;
          iExp = expChip(b, nStb);
          qDue = 5;
          qExp = expChip(b, nStb + 1);
        end
        nStb++;
      end
    end
  end

  task automatic resetMonitor();
    nStb = 0; accCount = 0; lastStb = -1; iDue = 0; qDue = 0;
  endtask

  // Opens a stream and feeds count bytes; kind 0 also pulses start mid-stream.
  task automatic feed(input int count, input int kind, input logic [7:0] firstByte);
    int sent = 0;
    bit pulsed = 0;
    bit checkActive = 0;
    start = 1'b1;
    inValid = 1'b1;
    inData = firstByte;
    while (sent < count) begin
      if (inReady) begin
        accepted[accCount] = inData;
        accCount++;
        sent++;
      end
      @(negedge clk);
      start = 1'b0;
      if (checkActive) begin
        check(active == 1'b1, "R10 start while active", active, 1);
        checkActive = 0;
      end
      if (kind == 0 && sent == 100 && !pulsed && active && !inReady) begin
        start = 1'b1;
        pulsed = 1;
        checkActive = 1;
      end
      if (sent < count && accCount == sent) inData = firstByte + 8'(sent);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!inReady, "R12 inReady", inReady, 0);
    check(!chipStb, "R12 chipStb", chipStb, 0);
    check(!chipVal, "R12 chipVal", chipVal, 0);
    check(!iChip && !qChip, "R12 rails", {iChip, qChip}, 0);
    check(!underrun, "R12 underrun", underrun, 0);
    check(!active, "R12 active", active, 0);

    // All 256 byte values back to back.
    resetMonitor();
    monitorOn = 1;
    feed(256, 0, 8'h00);
    while (!underrun) @(negedge clk);
    check(nStb == 256 * 64, "R8 strobe count", nStb, 256 * 64);
    check(!active && !chipStb && !iChip && !qChip, "R9 quiet after underrun",
          {active, chipStb, iChip, qChip}, 0);
    repeat (20) @(negedge clk);
    check(nStb == 256 * 64 && !iChip && !qChip, "R9 stays quiet", nStb, 256 * 64);

    // Start with nothing offered.
    resetMonitor();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!underrun, "R11 start clears underrun", underrun, 0);
    @(negedge clk);
    check(underrun, "R11 underrun with no byte", underrun, 1);
    check(!active, "R11 no run", active, 0);
    repeat (10) @(negedge clk);
    check(nStb == 0, "R11 no chips sent", nStb, 0);

    // Single byte stream after an underrun.
    resetMonitor();
    feed(1, 1, 8'hA5);
    check(!underrun, "R11 cleared by start", underrun, 1'b0);
    while (!underrun) @(negedge clk);
    check(nStb == 64, "R9 single byte chips", nStb, 64);

    monitorOn = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule